// File: doc/BRIEF.md
# Dual-Protocol Host Bus Front End

This block sits between an external microcontroller bus and the command decoder of a display controller. A host can reach it in three ways, chosen by a static mode input. The first is a parallel bus with separate active-low read and write strobes. The second is a parallel bus with one read/write direction level and an active-high enable pulse. The third is a clocked serial input that carries each byte most significant bit first. Whichever path is in use, the block delivers one uniform stream to the controller core: an 8-bit byte, a flag that marks the byte as command or display data, and single-cycle write or read pulses in the system clock domain.

All host pins are asynchronous to the system clock and pass through a two-flop synchronizer. An access is reported on its trailing strobe edge, so each completed host transfer yields exactly one internal pulse. During parallel reads the block drives the data bus from the raw pins. It drives a status byte when the register-select line is low and the read-data byte when it is high. The controller itself performs all decoding on its own clock and needs no host clock.

Top module: `mpu_host_if`

## Requirements
- R1: While reset is asserted and right after it is released, `wr_stb_o`, `rd_stb_o` and `bus_oe_o` are 0.
- R2: In mode 2'b00, a low pulse on `wr_rw_i` (write strobe) with `cs_n_i` low gives exactly one `wr_stb_o` pulse. The pulse carries the bus byte and comes at most 4 clock cycles after the strobe rises.
- R3: `is_data_o` reports the register-select level of the access: 0 (command or status) when `a0_i` was low and 1 (display data) when it was high.
- R4: In mode 2'b01, a high pulse on `rd_e_i` (enable) with `wr_rw_i` low gives exactly one `wr_stb_o` pulse with the bus byte, after enable falls.
- R5: In mode 2'b01, a high pulse on enable with `wr_rw_i` high is a read. It gives one `rd_stb_o` pulse and no write pulse.
- R6: In mode 2'b00, a low pulse on `rd_e_i` (read strobe) gives one `rd_stb_o` pulse and no write pulse.
- R7: During a parallel read with `cs_n_i` low, `bus_oe_o` is 1 and `bus_d_o` equals `status_i` when `a0_i` is 0, or `rdata_i` when `a0_i` is 1.
- R8: In mode 2'b10 or 2'b11 (serial), bits shift in on rising `sclk_i`, MSB first. After the 8th rising edge, one `wr_stb_o` pulse delivers the byte, with `a0_i` taken at that edge.
- R9: In serial mode, a high `cs_n_i` clears the bit count, so a partial byte is discarded.
- R10: With `cs_n_i` high, no strobe activity produces any pulse.
- R11: Every pulse is one cycle wide, and `wr_stb_o` and `rd_stb_o` are never high together.
- R12: In serial mode, `bus_oe_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Host style: 00 strobe pair, 01 direction+enable, 1x serial |
| cs_n_i | input | 1 | Active-low chip select |
| a0_i | input | 1 | Register select: 0 command/status, 1 display data |
| rd_e_i | input | 1 | Read strobe (mode 00) or enable (mode 01) |
| wr_rw_i | input | 1 | Write strobe (mode 00) or read/write level (mode 01) |
| bus_d_i | input | 8 | Parallel data from host |
| bus_d_o | output | 8 | Parallel data to host during reads |
| bus_oe_o | output | 1 | Data bus output enable |
| sclk_i | input | 1 | Serial shift clock |
| sdi_i | input | 1 | Serial data in |
| status_i | input | 8 | Status byte returned on command-side reads |
| rdata_i | input | 8 | Display read-data byte |
| byte_o | output | 8 | Received byte |
| is_data_o | output | 1 | Command (0) or data (1) flag for the pulse |
| wr_stb_o | output | 1 | Single-cycle write pulse |
| rd_stb_o | output | 1 | Single-cycle read-completed pulse |

## Verification
A stale previous-level register or a mis-decoded direction shows up at the ports within four clock cycles of the trailing strobe edge. It appears as a missing, doubled or wrong-typed pulse, or as a byte or flag that differs from the one the host drove. A serial bit counter that keeps state across a deselect has a delayed effect. It shifts every later byte, which becomes visible at the first full byte sent after a partial one. A wrong read select is visible at once on `bus_d_o` while the read strobe is held.

// File: rtl/mpu_host_pkg.sv
package mpu_host_pkg;
  typedef enum logic [1:0] {
    HOST_STROBE_PAIR = 2'b00,
    HOST_DIR_ENABLE  = 2'b01,
    HOST_SERIAL      = 2'b10,
    HOST_SERIAL_ALT  = 2'b11
  } host_mode_e;

  function automatic logic mode_is_serial(input logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/mhi_sync.sv
module mhi_sync #(
  parameter int          W      = 8,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic [W-1:0] src;
    if (i == 0) begin : g_first
      assign src = d;
    end else begin : g_next
      assign src = stg[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= RST;
      else        stg[i] <= src;
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/mhi_par.sv
module mhi_par #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          is_dir_en,
  input  logic          cs_n,
  input  logic          a0,
  input  logic          rd_e,
  input  logic          wr_rw,
  input  logic [DW-1:0] d,
  output logic          wr_ev,
  output logic          rd_ev,
  output logic [DW-1:0] ev_byte,
  output logic          ev_flag
);
  logic          wr_act, rd_act;
  logic          wr_prev_q, rd_prev_q, hold_a0_q;
  logic [DW-1:0] hold_d_q;
  logic          hold_a0_n;
  logic [DW-1:0] hold_d_n;

  always_comb begin
    wr_act = en && !cs_n && (is_dir_en ? (rd_e && !wr_rw) : !wr_rw);
    rd_act = en && !cs_n && (is_dir_en ? (rd_e &&  wr_rw) : !rd_e);
    hold_d_n  = hold_d_q;
    hold_a0_n = hold_a0_q;
    if (wr_act || rd_act) begin
      hold_d_n  = d;
      hold_a0_n = a0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_prev_q <= 1'b0;
      rd_prev_q <= 1'b0;
      hold_d_q  <= '0;
      hold_a0_q <= 1'b0;
    end else begin
      wr_prev_q <= wr_act;
      rd_prev_q <= rd_act;
      hold_d_q  <= hold_d_n;
      hold_a0_q <= hold_a0_n;
    end
  end

  assign wr_ev   = wr_prev_q && !wr_act;
  assign rd_ev   = rd_prev_q && !rd_act;
  assign ev_byte = hold_d_q;
  assign ev_flag = hold_a0_q;
endmodule

// File: rtl/mhi_ser.sv
module mhi_ser #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          cs_n,
  input  logic          sclk,
  input  logic          sdi,
  input  logic          a0,
  output logic          ev,
  output logic [DW-1:0] ev_byte,
  output logic          ev_flag
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic [DW-1:0] sh_q, sh_n;
  logic          sclk_q;
  logic          rise;

  always_comb begin
    rise  = sclk && !sclk_q;
    cnt_n = cnt_q;
    sh_n  = sh_q;
    if (!en || cs_n) begin
      cnt_n = '0;
    end else if (rise) begin
      sh_n  = {sh_q[DW-2:0], sdi};
      cnt_n = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      sh_q   <= sh_n;
      sclk_q <= sclk;
    end
  end

  assign ev      = en && !cs_n && rise && (cnt_q == LAST);
  assign ev_byte = {sh_q[DW-2:0], sdi};
  assign ev_flag = a0;
endmodule

// File: rtl/mpu_host_if.sv
module mpu_host_if
  import mpu_host_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_i,
  input  logic          cs_n_i,
  input  logic          a0_i,
  input  logic          rd_e_i,
  input  logic          wr_rw_i,
  input  logic [DW-1:0] bus_d_i,
  output logic [DW-1:0] bus_d_o,
  output logic          bus_oe_o,
  input  logic          sclk_i,
  input  logic          sdi_i,
  input  logic [DW-1:0] status_i,
  input  logic [DW-1:0] rdata_i,
  output logic [DW-1:0] byte_o,
  output logic          is_data_o,
  output logic          wr_stb_o,
  output logic          rd_stb_o
);
  localparam int SW = DW + 6;
  localparam logic [SW-1:0] SYNC_RST = {1'b1, {(SW-1){1'b0}}};

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_q_n = rst_pipe_q[1];

  logic          ser;
  logic          s_cs_n, s_a0, s_rd_e, s_wr_rw, s_sclk, s_sdi;
  logic [DW-1:0] s_d;

  assign ser = mode_is_serial(mode_i);

  mhi_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_q_n),
    .d     ({cs_n_i, a0_i, rd_e_i, wr_rw_i, sclk_i, sdi_i, bus_d_i}),
    .q     ({s_cs_n, s_a0, s_rd_e, s_wr_rw, s_sclk, s_sdi, s_d})
  );

  logic          p_wr, p_rd, p_flag, q_ev, q_flag;
  logic [DW-1:0] p_byte, q_byte;

  mhi_par #(.DW(DW)) u_par (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .en        (!ser),
    .is_dir_en (mode_i[0]),
    .cs_n      (s_cs_n),
    .a0        (s_a0),
    .rd_e      (s_rd_e),
    .wr_rw     (s_wr_rw),
    .d         (s_d),
    .wr_ev     (p_wr),
    .rd_ev     (p_rd),
    .ev_byte   (p_byte),
    .ev_flag   (p_flag)
  );

  mhi_ser #(.DW(DW)) u_ser (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .en      (ser),
    .cs_n    (s_cs_n),
    .sclk    (s_sclk),
    .sdi     (s_sdi),
    .a0      (s_a0),
    .ev      (q_ev),
    .ev_byte (q_byte),
    .ev_flag (q_flag)
  );

  // output stage
  logic          wr_n, rd_n, flag_n;
  logic [DW-1:0] byte_n;

  always_comb begin
    wr_n   = ser ? q_ev : p_wr;
    rd_n   = !ser && p_rd;
    byte_n = byte_o;
    flag_n = is_data_o;
    if (wr_n || rd_n) begin
      byte_n = ser ? q_byte : p_byte;
      flag_n = ser ? q_flag : p_flag;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      wr_stb_o  <= 1'b0;
      rd_stb_o  <= 1'b0;
      byte_o    <= '0;
      is_data_o <= 1'b0;
    end else begin
      wr_stb_o  <= wr_n;
      rd_stb_o  <= rd_n;
      byte_o    <= byte_n;
      is_data_o <= flag_n;
    end
  end

  // read data path straight from the pins
  always_comb begin
    bus_oe_o = rst_q_n && !ser && !cs_n_i &&
               (mode_i[0] ? (rd_e_i && wr_rw_i) : !rd_e_i);
    bus_d_o  = a0_i ? rdata_i : status_i;
  end
endmodule

// File: rtl/mpu_host_if_chk.sv
module mpu_host_if_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_i,
  input logic       cs_n_i,
  input logic       bus_oe_o,
  input logic       wr_stb_o,
  input logic       rd_stb_o
);
  assert_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb_o && rd_stb_o));

  assert_wr_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |=> !wr_stb_o);

  assert_rd_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb_o |=> !rd_stb_o);

  assert_ser_no_drive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i[1] |-> !bus_oe_o);

  assert_deselect_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cs_n_i, 1) && $past(cs_n_i, 2) && $past(cs_n_i, 3) && $past(cs_n_i, 4))
      |-> (!wr_stb_o && !rd_stb_o));
endmodule

bind mpu_host_if mpu_host_if_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode_i   (mode_i),
  .cs_n_i   (cs_n_i),
  .bus_oe_o (bus_oe_o),
  .wr_stb_o (wr_stb_o),
  .rd_stb_o (rd_stb_o)
);

// File: tb/tb_mpu_host_if.sv
`timescale 1ns/1ps
module tb_mpu_host_if;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode;
  logic       cs_n, a0, rd_e, wr_rw, sclk, sdi;
  logic [7:0] bus_d, bus_q, byte_q;
  logic       bus_oe, is_data, wr_stb, rd_stb;
  localparam logic [7:0] STAT = 8'hA5;
  localparam logic [7:0] RDAT = 8'h3C;

  always #10 clk = ~clk;

  mpu_host_if dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .cs_n_i(cs_n), .a0_i(a0),
    .rd_e_i(rd_e), .wr_rw_i(wr_rw), .bus_d_i(bus_d), .bus_d_o(bus_q),
    .bus_oe_o(bus_oe), .sclk_i(sclk), .sdi_i(sdi), .status_i(STAT),
    .rdata_i(RDAT), .byte_o(byte_q), .is_data_o(is_data),
    .wr_stb_o(wr_stb), .rd_stb_o(rd_stb)
  );

  int total = 0, bad = 0, cyc = 0;
  int wr_cnt = 0, rd_cnt = 0, wide = 0, last_cyc = 0;
  logic [7:0] last_byte;
  logic last_flag, prev_w, prev_r;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_stb || rd_stb) begin
        last_byte = byte_q; last_flag = is_data; last_cyc = cyc;
      end
      if (wr_stb) wr_cnt++;
      if (rd_stb) rd_cnt++;
      if ((wr_stb && prev_w) || (rd_stb && prev_r)) wide++;
    end
    prev_w = wr_stb; prev_r = rd_stb;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // vector: {mode[1:0], a0, is_read, data[7:0]}
  localparam int NV = 8;
  localparam logic [11:0] VEC [NV] = '{
    {2'b00, 1'b0, 1'b0, 8'h3F},
    {2'b00, 1'b1, 1'b0, 8'h81},
    {2'b01, 1'b0, 1'b0, 8'h40},
    {2'b01, 1'b1, 1'b0, 8'hC7},
    {2'b00, 1'b0, 1'b1, 8'h00},
    {2'b00, 1'b1, 1'b1, 8'h00},
    {2'b01, 1'b0, 1'b1, 8'h00},
    {2'b01, 1'b1, 1'b1, 8'h00}
  };

  logic oe_seen;
  logic [7:0] dq_seen;
  int trail;

  task automatic par_access(input logic [1:0] m, input logic a, input logic rd,
                            input logic [7:0] d, input logic sel);
    @(negedge clk);
    cs_n = 1'b1; mode = m; a0 = a; bus_d = d;
    if (m == 2'b00) begin rd_e = 1'b1; wr_rw = 1'b1; end
    else begin rd_e = 1'b0; wr_rw = rd; end
    repeat (4) @(negedge clk);
    cs_n = !sel;
    repeat (2) @(negedge clk);
    if (m == 2'b00) begin if (rd) rd_e = 1'b0; else wr_rw = 1'b0; end
    else rd_e = 1'b1;
    repeat (4) @(negedge clk);
    oe_seen = bus_oe; dq_seen = bus_q;
    if (m == 2'b00) begin rd_e = 1'b1; wr_rw = 1'b1; end
    else rd_e = 1'b0;
    trail = cyc;
    repeat (8) @(negedge clk);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic ser_bits(input logic a, input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      sdi = b[i];
      a0 = (i == 0) ? a : !a;
      repeat (2) @(negedge clk);
      sclk = 1'b1;
      repeat (3) @(negedge clk);
      sclk = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int w0, r0;
    rst_n = 1'b0; mode = 2'b00; cs_n = 1'b1; a0 = 1'b0; rd_e = 1'b1;
    wr_rw = 1'b1; sclk = 1'b0; sdi = 1'b0; bus_d = 8'h00;
    repeat (3) @(negedge clk);
    chk(!wr_stb && !rd_stb && !bus_oe, "R1 in reset", {wr_stb, rd_stb, bus_oe}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!wr_stb && !rd_stb && !bus_oe, "R1 after release", {wr_stb, rd_stb, bus_oe}, 0);
    chk(wr_cnt == 0 && rd_cnt == 0, "R1 no pulse", wr_cnt + rd_cnt, 0);

    // table walk: parallel writes and reads (R2 R3 R4 R5 R6 R7)
    for (int v = 0; v < NV; v++) begin
      logic [1:0] m; logic a, rd; logic [7:0] d;
      {m, a, rd, d} = VEC[v];
      w0 = wr_cnt; r0 = rd_cnt;
      par_access(m, a, rd, d, 1'b1);
      if (!rd) begin
        chk(wr_cnt == w0 + 1 && rd_cnt == r0, m[0] ? "R4 one write" : "R2 one write",
            wr_cnt - w0, 1);
        chk(last_byte == d, m[0] ? "R4 byte" : "R2 byte", last_byte, d);
        chk(last_cyc - trail <= 4 && last_cyc > trail, "R2 latency", last_cyc - trail, 4);
      end else begin
        chk(rd_cnt == r0 + 1 && wr_cnt == w0, m[0] ? "R5 one read" : "R6 one read",
            rd_cnt - r0, 1);
        chk(oe_seen == 1'b1, "R7 drive", oe_seen, 1);
        chk(dq_seen == (a ? RDAT : STAT), "R7 source", dq_seen, a ? RDAT : STAT);
      end
      chk(last_flag == a, "R3 flag", last_flag, a);
    end

    // R10: deselected strobes are ignored in both parallel styles
    w0 = wr_cnt; r0 = rd_cnt;
    par_access(2'b00, 1'b1, 1'b0, 8'h55, 1'b0);
    par_access(2'b01, 1'b0, 1'b0, 8'h66, 1'b0);
    par_access(2'b01, 1'b0, 1'b1, 8'h00, 1'b0);
    chk(wr_cnt == w0 && rd_cnt == r0, "R10 deselected", wr_cnt + rd_cnt - w0 - r0, 0);
    chk(oe_seen == 1'b0, "R10 no drive", oe_seen, 0);

    // serial mode (R8 R3)
    @(negedge clk);
    mode = 2'b10; rd_e = 1'b1; wr_rw = 1'b1;
    repeat (4) @(negedge clk);
    cs_n = 1'b0;
    w0 = wr_cnt;
    ser_bits(1'b1, 8'hB4, 8);
    chk(wr_cnt == w0 + 1, "R8 one byte", wr_cnt - w0, 1);
    chk(last_byte == 8'hB4, "R8 msb first", last_byte, 8'hB4);
    chk(last_flag == 1'b1, "R8 a0 at last edge", last_flag, 1);
    ser_bits(1'b0, 8'h0E, 8);
    chk(last_byte == 8'h0E && last_flag == 1'b0, "R3 serial cmd", {last_flag, last_byte}, 8'h0E);

    // R9: partial byte then deselect
    w0 = wr_cnt;
    ser_bits(1'b1, 8'hFF, 3);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    ser_bits(1'b1, 8'h92, 8);
    chk(wr_cnt == w0 + 1, "R9 count", wr_cnt - w0, 1);
    chk(last_byte == 8'h92, "R9 fresh byte", last_byte, 8'h92);

    // R12: read-like strobe level in serial mode
    r0 = rd_cnt;
    rd_e = 1'b0;
    repeat (4) @(negedge clk);
    chk(bus_oe == 1'b0, "R12 no drive", bus_oe, 0);
    rd_e = 1'b1;
    repeat (6) @(negedge clk);
    chk(rd_cnt == r0, "R12 no read", rd_cnt - r0, 0);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);

    chk(wide == 0, "R11 one cycle", wide, 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule